// File: doc/BRIEF.md
# Two-Stage Pipelined Four-Instruction Processor

This block is a small 32-bit processor core split into two pipeline stages. The front stage fetches the word at the program counter from a combinationally read instruction memory, decodes it and reads its operand values. It then places a decoded template (opcode, destination index and two operand values) in a single pipeline register that carries a valid flag. The back stage acts on that template. It adds, loads or stores through a data memory port that answers reads in the same cycle, or it resolves a branch-if-zero.

Fetch always guesses the sequential address. A taken branch found in the back stage redirects the program counter to the target and discards the word fetched in the same cycle, which leaves one empty slot. A build parameter chooses how read-after-write dependences on the instruction in the back stage are handled. In interlock mode the front stage holds and inserts an empty slot. In forwarding mode the result being written is steered straight into the operand being read, so no cycle is lost.

Top module: `pipe2_core`

## Requirements
- R1: After reset the program counter is 0, the pipeline register is empty and all 32 registers hold 0, so `imem_addr` reads 0 and `dmem_wen` is low.
- R2: An instruction word is 17 bits: bits [16:15] are the opcode (00 add, 01 branch-if-zero, 10 load, 11 store), and bits [14:10], [9:5], [4:0] are register fields A, B, C. Add writes reg[B]+reg[C] modulo 2^32 to reg[A].
- R3: Load writes mem[reg[B]] to reg[A]. Store writes reg[A] to mem[reg[B]] at the end of its execute cycle, so a load in the next instruction sees the new value. `dmem_wen` is high only for a valid store.
- R4: Branch-if-zero sets the program counter to reg[B] when reg[A] is 0, and discards the instruction fetched behind it. When reg[A] is non-zero, execution continues at the next address. A discarded or skipped instruction changes no register and no memory word.
- R5: Register 0 is an ordinary register that can be written and read like any other.
- R6: With forwarding off, if an instruction reads a register that a valid add or load in execute is writing, that instruction waits one cycle. The program counter holds and an empty slot enters the pipeline register. Register reads return the value from before the same cycle's write.
- R7: With forwarding on, a source register that matches the destination of the add or load in execute takes that result, and no dependence causes a wait.
- R8: Fetch speculates on pc+1. Both modes produce the same memory results as sequential execution of the program. In forwarding mode, a program with one taken branch reaches its final address after one cycle more than its count of executed instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Word address of the instruction being fetched (program counter) |
| imem_rdata | input | 17 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Word address for the load or store in execute |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dmem_wdata | output | 32 | Data to store |
| dmem_wen | output | 1 | Store enable, written at the clock edge |

## Verification
One program runs on a forwarding instance and on an interlocking instance side by side. It contains back-to-back load-to-use and add-to-use chains, an add that wraps to zero and then feeds a taken branch, a branch that is not taken, a store followed by a load from the same word, and register 0 used as a destination. The dependence chains separate the two modes by the program counter seen two cycles after reset and by the cycle in which the final address is reached. The taken branch shows that the discarded instruction behind it leaves no trace in memory. The store-then-load pair and the register 0 result show write timing and register behaviour, and a sequential model in the bench supplies the expected contents of every data word.

// File: rtl/pipe2_pkg.sv
package pipe2_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OP_W    = 2;
    localparam int INSTR_W = OP_W + 3 * RIDX_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_BZ  = 2'b01,
        OP_LD  = 2'b10,
        OP_ST  = 2'b11
    } op_e;

    // Decoded template: add a=op1 b=op2; branch a=cond b=target;
    // load b=address; store a=value b=address.
    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
    } tmpl_t;
endpackage

// File: rtl/pipe2_regfile.sv
module pipe2_regfile
    import pipe2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rx_idx,
    input  logic [RIDX_W-1:0] ry_idx,
    output logic [XLEN-1:0]   rx_val,
    output logic [XLEN-1:0]   ry_val,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val
);
    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    // Reads see the contents before this cycle's write.
    assign rx_val = regs_q[rx_idx];
    assign ry_val = regs_q[ry_idx];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en) begin
            regs_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end
endmodule

// File: rtl/pipe2_decode.sv
module pipe2_decode
    import pipe2_pkg::*;
#(
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [RIDX_W-1:0]  rx_idx,
    output logic [RIDX_W-1:0]  ry_idx,
    input  logic [XLEN-1:0]    rx_val,
    input  logic [XLEN-1:0]    ry_val,
    input  logic               wb_en,
    input  logic [RIDX_W-1:0]  wb_idx,
    input  logic [XLEN-1:0]    wb_val,
    output tmpl_t              tmpl,
    output logic               stall
);
    localparam int FA_LO = 2 * RIDX_W;
    localparam int FB_LO = RIDX_W;

    op_e               op;
    logic [RIDX_W-1:0] fa;
    logic [RIDX_W-1:0] fb;
    logic [RIDX_W-1:0] fc;
    logic              uses_y;
    logic              hit_x;
    logic              hit_y;
    logic [XLEN-1:0]   x_val;
    logic [XLEN-1:0]   y_val;

    assign op = op_e'(instr[INSTR_W-1 -: OP_W]);
    assign fa = instr[FA_LO +: RIDX_W];
    assign fb = instr[FB_LO +: RIDX_W];
    assign fc = instr[0 +: RIDX_W];

    // Port X always reads field B; port Y reads C for add, A otherwise.
    assign rx_idx = fb;
    assign ry_idx = (op == OP_ADD) ? fc : fa;
    assign uses_y = (op != OP_LD);

    assign hit_x = wb_en && (wb_idx == rx_idx);
    assign hit_y = wb_en && (wb_idx == ry_idx) && uses_y;

    assign x_val = (BYPASS_EN && hit_x) ? wb_val : rx_val;
    assign y_val = (BYPASS_EN && hit_y) ? wb_val : ry_val;
    assign stall = !BYPASS_EN && (hit_x || hit_y);

    always_comb begin
        tmpl.valid = 1'b1;
        tmpl.op    = op;
        tmpl.dst   = fa;
        if (op == OP_ADD) begin
            tmpl.a = x_val;
            tmpl.b = y_val;
        end else begin
            tmpl.a = y_val;
            tmpl.b = x_val;
        end
    end
endmodule

// File: rtl/pipe2_exec.sv
module pipe2_exec
    import pipe2_pkg::*;
(
    input  tmpl_t              ex,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_wen,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]    wb_val,
    output logic               taken,
    output logic [XLEN-1:0]    target
);
    assign dmem_addr  = ex.b;
    assign dmem_wdata = ex.a;
    assign dmem_wen   = ex.valid && (ex.op == OP_ST);

    assign wb_en  = ex.valid && ((ex.op == OP_ADD) || (ex.op == OP_LD));
    assign wb_idx = ex.dst;
    assign wb_val = (ex.op == OP_ADD) ? (ex.a + ex.b) : dmem_rdata;

    assign taken  = ex.valid && (ex.op == OP_BZ) && (ex.a == '0);
    assign target = ex.b;
endmodule

// File: rtl/pipe2_core.sv
module pipe2_core
    import pipe2_pkg::*;
#(
    parameter bit BYPASS_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic [XLEN-1:0]    dmem_wdata,
    output logic               dmem_wen
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        tmpl_t           ex;
    } state_t;

    state_t            st_d;
    state_t            st_q;

    logic [RIDX_W-1:0] rx_idx;
    logic [RIDX_W-1:0] ry_idx;
    logic [XLEN-1:0]   rx_val;
    logic [XLEN-1:0]   ry_val;
    logic              wb_en;
    logic [RIDX_W-1:0] wb_idx;
    logic [XLEN-1:0]   wb_val;
    logic              br_taken;
    logic [XLEN-1:0]   br_target;
    logic              dec_stall;
    tmpl_t             dec_tmpl;

    assign imem_addr = st_q.pc;

    pipe2_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_idx (rx_idx),
        .ry_idx (ry_idx),
        .rx_val (rx_val),
        .ry_val (ry_val),
        .wr_en  (wb_en),
        .wr_idx (wb_idx),
        .wr_val (wb_val)
    );

    pipe2_decode #(.BYPASS_EN(BYPASS_EN)) u_dec (
        .instr  (imem_rdata),
        .rx_idx (rx_idx),
        .ry_idx (ry_idx),
        .rx_val (rx_val),
        .ry_val (ry_val),
        .wb_en  (wb_en),
        .wb_idx (wb_idx),
        .wb_val (wb_val),
        .tmpl   (dec_tmpl),
        .stall  (dec_stall)
    );

    pipe2_exec u_ex (
        .ex         (st_q.ex),
        .dmem_rdata (dmem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_wen   (dmem_wen),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_val     (wb_val),
        .taken      (br_taken),
        .target     (br_target)
    );

    always_comb begin
        st_d = st_q;
        if (br_taken) begin
            st_d.pc       = br_target;
            st_d.ex.valid = 1'b0;
        end else if (dec_stall) begin
            st_d.ex.valid = 1'b0;
        end else begin
            st_d.ex = dec_tmpl;
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pipe2_core_chk.sv
module pipe2_core_chk
    import pipe2_pkg::*;
#(
    parameter bit BYPASS_EN = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic            ex_valid,
    input logic            taken,
    input logic [XLEN-1:0] target,
    input logic            stall,
    input logic            dmem_wen
);
    AST_WEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) dmem_wen |-> ex_valid); // R3
    AST_TAKEN_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) taken |=> !ex_valid); // R4
    AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) taken |=> (pc == $past(target))); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> ((pc == $past(pc)) && !ex_valid)); // R6
    AST_FWD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n) stall |-> (BYPASS_EN == 1'b0)); // R7
    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (!taken && !stall) |=> (pc == $past(pc) + 32'd1)); // R8
endmodule

bind pipe2_core pipe2_core_chk #(.BYPASS_EN(BYPASS_EN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (st_q.pc),
    .ex_valid (st_q.ex.valid),
    .taken    (br_taken),
    .target   (br_target),
    .stall    (dec_stall),
    .dmem_wen (dmem_wen)
);

// File: tb/tb_pipe2_core.sv
`timescale 1ns/1ps
module tb_pipe2_core;
    localparam int HALT_PC = 32;
    localparam int BR_TGT  = 13;

    function automatic logic [16:0] enc(int op, int a, int b, int c);
        logic [1:0] o = op[1:0];
        return {o, a[4:0], b[4:0], c[4:0]};
    endfunction

    // op: 0 add(A=B+C), 1 bz(cond A, target B), 2 load(A=mem[B]), 3 store(mem[B]=A)
    localparam logic [16:0] PROG [0:32] = '{
        enc(2, 1, 31, 0),   // 0  R1 = mem[0] = 1
        enc(0, 2, 1, 1),    // 1  R2 = 2      load-use
        enc(0, 3, 2, 1),    // 2  R3 = 3      add-use
        enc(2, 30, 2, 0),   // 3  R30 = halt address
        enc(2, 29, 3, 0),   // 4  R29 = branch target
        enc(0, 4, 3, 1),    // 5  R4 = 4
        enc(2, 5, 4, 0),    // 6  R5 = 0x12345678
        enc(0, 6, 4, 1),    // 7  R6 = 5
        enc(2, 7, 6, 0),    // 8  R7 = 0xFFFFFFFF
        enc(0, 8, 7, 1),    // 9  R8 = 0 (wraps)
        enc(1, 8, 29, 0),   // 10 taken branch
        enc(0, 9, 5, 5),    // 11 discarded
        enc(3, 1, 4, 0),    // 12 skipped store
        enc(2, 10, 1, 0),   // 13 R10 = 16
        enc(3, 5, 10, 0),   // 14 mem[16] = R5
        enc(0, 11, 10, 1),  // 15 R11 = 17
        enc(3, 8, 11, 0),   // 16 mem[17] = R8
        enc(1, 1, 29, 0),   // 17 not taken
        enc(0, 12, 11, 1),  // 18 R12 = 18
        enc(0, 13, 5, 7),   // 19 R13 = R5 - 1
        enc(3, 13, 12, 0),  // 20 mem[18] = R13
        enc(0, 14, 12, 1),  // 21 R14 = 19
        enc(3, 9, 14, 0),   // 22 mem[19] = R9
        enc(0, 15, 14, 1),  // 23 R15 = 20
        enc(3, 5, 15, 0),   // 24 mem[20] = R5
        enc(2, 16, 15, 0),  // 25 R16 = mem[20]
        enc(0, 17, 16, 1),  // 26 R17 = R16 + 1
        enc(0, 18, 15, 1),  // 27 R18 = 21
        enc(3, 17, 18, 0),  // 28 mem[21] = R17
        enc(0, 0, 17, 17),  // 29 R0 = 2*R17
        enc(0, 19, 18, 1),  // 30 R19 = 22
        enc(3, 0, 19, 0),   // 31 mem[22] = R0
        enc(1, 31, 30, 0)   // 32 halt loop
    };

    function automatic logic [31:0] init_val(int i);
        case (i)
            0: return 32'd1;
            1: return 32'd16;
            2: return HALT_PC;
            3: return BR_TGT;
            4: return 32'h12345678;
            5: return 32'hFFFFFFFF;
            default: return 32'h100 + i;
        endcase
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [16:0] imem [0:63];
    logic [31:0] dmem_b [0:31];
    logic [31:0] dmem_s [0:31];
    logic [31:0] ref_mem [0:31];
    logic [31:0] ref_reg [0:31];

    logic [31:0] imem_addr_b, imem_addr_s, dmem_addr_b, dmem_addr_s;
    logic [31:0] dmem_wdata_b, dmem_wdata_s, dmem_rdata_b, dmem_rdata_s;
    logic [16:0] imem_rdata_b, imem_rdata_s;
    logic        dmem_wen_b, dmem_wen_s;

    assign imem_rdata_b = imem[imem_addr_b[5:0]];
    assign imem_rdata_s = imem[imem_addr_s[5:0]];
    assign dmem_rdata_b = dmem_b[dmem_addr_b[4:0]];
    assign dmem_rdata_s = dmem_s[dmem_addr_s[4:0]];

    always @(posedge clk) begin
        if (dmem_wen_b) dmem_b[dmem_addr_b[4:0]] <= dmem_wdata_b;
        if (dmem_wen_s) dmem_s[dmem_addr_s[4:0]] <= dmem_wdata_s;
    end

    pipe2_core #(.BYPASS_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr_b), .imem_rdata(imem_rdata_b),
        .dmem_addr(dmem_addr_b), .dmem_rdata(dmem_rdata_b),
        .dmem_wdata(dmem_wdata_b), .dmem_wen(dmem_wen_b)
    );

    pipe2_core #(.BYPASS_EN(1'b0)) dut_s (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr_s), .imem_rdata(imem_rdata_s),
        .dmem_addr(dmem_addr_s), .dmem_rdata(dmem_rdata_s),
        .dmem_wdata(dmem_wdata_s), .dmem_wen(dmem_wen_s)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_ref();
        logic [31:0] pc = 0;
        for (int k = 0; k < 32; k++) begin
            ref_mem[k] = init_val(k);
            ref_reg[k] = '0;
        end
        for (int step = 0; step < 1000 && pc != HALT_PC; step++) begin
            logic [16:0] w = imem[pc[5:0]];
            logic [4:0] fa = w[14:10];
            logic [4:0] fb = w[9:5];
            logic [4:0] fc = w[4:0];
            case (w[16:15])
                2'b00: begin ref_reg[fa] = ref_reg[fb] + ref_reg[fc]; pc = pc + 1; end
                2'b01: pc = (ref_reg[fa] == 0) ? ref_reg[fb] : pc + 1;
                2'b10: begin ref_reg[fa] = ref_mem[ref_reg[fb][4:0]]; pc = pc + 1; end
                default: begin ref_mem[ref_reg[fb][4:0]] = ref_reg[fa]; pc = pc + 1; end
            endcase
        end
    endtask

    initial begin
        int halt_b = -1;
        int halt_s = -1;
        for (int k = 0; k < 64; k++) imem[k] = (k <= 32) ? PROG[k] : '0;
        for (int k = 0; k < 32; k++) begin
            dmem_b[k] = init_val(k);
            dmem_s[k] = init_val(k);
        end
        run_ref();

        repeat (3) @(negedge clk);
        chk("R1", "pc after reset (fwd)", imem_addr_b, 32'd0);
        chk("R1", "store enable after reset (fwd)", {31'b0, dmem_wen_b}, 32'd0);
        chk("R1", "pc after reset (interlock)", imem_addr_s, 32'd0);
        chk("R1", "store enable after reset (interlock)", {31'b0, dmem_wen_s}, 32'd0);
        rst_n = 1'b1;

        for (int n = 1; n <= 150; n++) begin
            @(negedge clk);
            if (n == 2) begin
                chk("R7", "fwd pc after load-use pair", imem_addr_b, 32'd2);
                chk("R6", "interlock pc held on load-use", imem_addr_s, 32'd1);
            end
            if (halt_b < 0 && imem_addr_b == HALT_PC) halt_b = n;
            if (halt_s < 0 && imem_addr_s == HALT_PC) halt_s = n;
        end

        chk("R8", "fwd cycles to final address", halt_b, 32'd31);
        chk("R6", "interlock slower than fwd", {31'b0, (halt_s > halt_b)}, 32'd1);

        // Directed results, computed by hand from the requirements
        chk("R3", "mem[16] stored through fwd", dmem_b[16], 32'h12345678);
        chk("R2", "mem[17] add wrap to zero", dmem_b[17], 32'h0);
        chk("R2", "mem[18] add sum", dmem_b[18], 32'h12345677);
        chk("R4", "mem[19] discarded add left reg at 0", dmem_b[19], 32'h0);
        chk("R4", "mem[4] skipped store", dmem_b[4], 32'h12345678);
        chk("R3", "mem[21] store then load", dmem_b[21], 32'h12345679);
        chk("R5", "mem[22] register 0 written", dmem_b[22], 32'h2468ACF2);
        chk("R5", "mem[22] register 0 (interlock)", dmem_s[22], 32'h2468ACF2);
        chk("R4", "mem[19] interlock", dmem_s[19], 32'h0);

        for (int k = 0; k < 32; k++) begin
            chk("R8", $sformatf("fwd mem[%0d] vs sequential", k), dmem_b[k], ref_mem[k]);
            chk("R8", $sformatf("interlock mem[%0d] vs sequential", k), dmem_s[k], ref_mem[k]);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule